// File: doc/BRIEF.md
# DSP Address Generation Unit

This unit produces data-memory addresses for register-indirect loads and stores. It runs beside the arithmetic datapath. It keeps three small register files. The index registers hold addresses. The modify registers hold signed increments. The length registers hold circular-buffer sizes. Each access request picks one register from each file. The pick comes either from three pointer registers inside the unit or from select fields that the instruction supplies, and the request chooses which source to use.

The address comes out combinationally in the request cycle. The unit then rewrites the chosen index register at the next clock edge, as the addressing mode dictates. Supported updates are step by plus or minus one, step by a modify register, and modulo stepping inside a circular buffer. An indexed mode issues index plus modify and leaves the index alone. A separate immediate-load port writes any register, including the pointers. That port is the slow path. Address updates made during accesses cost no extra cycles.

Top module: `addr_gen_unit`

## Requirements
- R1: Mode 0 (plain indirect) drives `ea` with the selected index register and leaves that register unchanged.
- R2: Mode 1 and mode 2 drive `ea` with the old index value. At the next edge they store index+1 or index-1, wrapping modulo 2^16. No modify register is used.
- R3: Mode 3 drives `ea` with the old index value. At the next edge it stores the index plus the selected modify register, read as a signed two's-complement value.
- R4: Mode 4 (indexed) drives `ea` with index plus modify, modulo 2^16, and leaves the index register unchanged.
- R5: Modes 5, 6 and 7 step by the modify register, +1 and -1 respectively, inside a circular buffer. L is the selected length and P is the smallest power of two at or above L. The buffer starts at the index with its low log2(P) bits cleared. The new offset is the old offset plus the step, raised by L if it is negative or lowered by L if it is at least L.
- R6: In modes 5 to 7, a selected length of zero gives plain linear stepping, the same as modes 3, 1 and 2.
- R7: With `req_use_ptr`=1 the index, modify and length registers are picked by the internal pointers. With `req_use_ptr`=0 they are picked by `req_isel`, `req_msel` and `req_lsel`.
- R8: An immediate load takes effect at the next edge. `ld_file` selects the target: 0 index, 1 modify, 2 length, 3 pointer. For the pointer file, `ld_sel` 0, 1 and 2 select the index, modify and length pointer, loaded from the low bits of `ld_data`. An access in the same cycle reads the values held before the load.
- R9: When an immediate load and an access update hit the same index register in one cycle, the loaded value is kept.
- R10: After reset every register, including the pointers, reads as zero.
- R11: `ea_valid` equals `req_valid` in the same cycle, and `ea` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_mode | input | 3 | Addressing mode 0..7 |
| req_use_ptr | input | 1 | 1: select through pointer registers, 0: through fields |
| req_isel | input | 2 | Index register field |
| req_msel | input | 2 | Modify register field |
| req_lsel | input | 2 | Length register field |
| ld_valid | input | 1 | Immediate load strobe |
| ld_file | input | 2 | Target file of the load |
| ld_sel | input | 2 | Register within the target file |
| ld_data | input | 16 | Immediate value |
| ea | output | 16 | Effective address |
| ea_valid | output | 1 | Address valid |

## Verification
Each step mode is tried with positive and negative increments and at the top of the 16-bit range. This separates true two's-complement wrap from saturation or sign errors. Modulo stepping is run up to both edges of a buffer whose length is not a power of two, and with a length of zero. This distinguishes wrap by length from wrap by power of two, and separates those from linear stepping. A pointer-selected access whose fields point at different registers shows which selection source was honoured. Same-cycle load and access pairs show whether an access sees old or new contents, and which write wins.

// File: rtl/addr_gen_unit.sv
module addr_gen_unit #(
  parameter int AW   = 16,
  parameter int NREG = 4,
  localparam int SW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_mode,
  input  logic          req_use_ptr,
  input  logic [SW-1:0] req_isel,
  input  logic [SW-1:0] req_msel,
  input  logic [SW-1:0] req_lsel,
  input  logic          ld_valid,
  input  logic [1:0]    ld_file,
  input  logic [SW-1:0] ld_sel,
  input  logic [AW-1:0] ld_data,
  output logic [AW-1:0] ea,
  output logic          ea_valid
);

  logic [NREG-1:0][AW-1:0] idx_rf, mod_rf, len_rf;
  logic [SW-1:0] ptr_i, ptr_m, ptr_l;
  logic [SW-1:0] isel, msel, lsel;
  logic [AW-1:0] cur_idx, cur_mod, cur_len;
  logic [AW-1:0] step, lin, mask, off, wrapped, nxt;
  logic [AW:0]   noff, noff_adj;
  logic          circ, upd;

  assign isel = req_use_ptr ? ptr_i : req_isel;
  assign msel = req_use_ptr ? ptr_m : req_msel;
  assign lsel = req_use_ptr ? ptr_l : req_lsel;

  assign cur_idx = idx_rf[isel];
  assign cur_mod = mod_rf[msel];
  assign cur_len = len_rf[lsel];

  always_comb begin
    case (req_mode)
      3'd1, 3'd6: step = AW'(1);
      3'd2, 3'd7: step = '1;
      3'd3, 3'd5: step = cur_mod;
      default:    step = '0;
    endcase
  end

  assign lin = cur_idx + step;

  always_comb begin
    mask = cur_len - AW'(1);
    for (int s = 1; s < AW; s = s * 2)
      mask = mask | (mask >> s);
  end

  assign off  = cur_idx & mask;
  assign noff = {1'b0, off} + {step[AW-1], step};

  always_comb begin
    if (noff[AW])
      noff_adj = noff + {1'b0, cur_len};
    else if (noff >= {1'b0, cur_len})
      noff_adj = noff - {1'b0, cur_len};
    else
      noff_adj = noff;
  end

  assign wrapped = (cur_idx & ~mask) + noff_adj[AW-1:0];
  assign circ    = req_mode[2] && (req_mode != 3'd4) && (cur_len != '0);
  assign nxt     = circ ? wrapped : lin;
  assign upd     = req_valid && (req_mode != 3'd0) && (req_mode != 3'd4);

  assign ea       = (req_mode == 3'd4) ? cur_idx + cur_mod : cur_idx;
  assign ea_valid = req_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_rf <= '0;
      mod_rf <= '0;
      len_rf <= '0;
      ptr_i  <= '0;
      ptr_m  <= '0;
      ptr_l  <= '0;
    end else begin
      if (upd)
        idx_rf[isel] <= nxt;
      if (ld_valid) begin
        case (ld_file)
          2'd0: idx_rf[ld_sel] <= ld_data;
          2'd1: mod_rf[ld_sel] <= ld_data;
          2'd2: len_rf[ld_sel] <= ld_data;
          default: begin
            if (ld_sel == SW'(0)) ptr_i <= ld_data[SW-1:0];
            if (ld_sel == SW'(1)) ptr_m <= ld_data[SW-1:0];
            if (ld_sel == SW'(2)) ptr_l <= ld_data[SW-1:0];
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/addr_gen_unit_chk.sv
module addr_gen_unit_chk #(
  parameter int AW   = 16,
  parameter int NREG = 4,
  localparam int SW  = $clog2(NREG)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic [2:0]              req_mode,
  input logic                    ld_valid,
  input logic [1:0]              ld_file,
  input logic [SW-1:0]           ld_sel,
  input logic [AW-1:0]           ld_data,
  input logic [SW-1:0]           isel,
  input logic [AW-1:0]           cur_idx,
  input logic [AW-1:0]           cur_len,
  input logic [NREG-1:0][AW-1:0] idx_rf
);

  function automatic logic [AW-1:0] pow2_mask(input logic [AW-1:0] len);
    logic [AW:0] p;
    p = 1;
    while (p < {1'b0, len}) p = p << 1;
    return p[AW-1:0] - AW'(1);
  endfunction

  logic          hit;
  logic [AW-1:0] cmask;
  assign hit   = ld_valid && (ld_file == 2'd0) && (ld_sel == isel);
  assign cmask = pow2_mask(cur_len);

  assert_no_update_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_mode == 3'd0 || req_mode == 3'd4) && !hit
    |=> idx_rf[$past(isel)] == $past(cur_idx));

  assert_post_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_mode == 3'd1 && !hit
    |=> idx_rf[$past(isel)] == $past(cur_idx) + AW'(1));

  assert_stay_in_buffer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_mode == 3'd6 || req_mode == 3'd7) && cur_len != '0
      && (cur_idx & cmask) < cur_len && !hit
    |=> (idx_rf[$past(isel)] & ~$past(cmask)) == ($past(cur_idx) & ~$past(cmask)));

  assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && ld_file == 2'd0
    |=> idx_rf[$past(ld_sel)] == $past(ld_data));

endmodule

bind addr_gen_unit addr_gen_unit_chk #(.AW(AW), .NREG(NREG)) u_chk (.*);

// File: tb/test_addr_gen_unit.sv
`timescale 1ns/1ps
module test_addr_gen_unit;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_use_ptr = 0, ld_valid = 0;
  logic [2:0] req_mode = 0;
  logic [1:0] req_isel = 0, req_msel = 0, req_lsel = 0, ld_file = 0, ld_sel = 0;
  logic [15:0] ld_data = 0, ea;
  logic ea_valid;

  addr_gen_unit i_addr_gen_unit (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  int exp_q[$];
  string tag_q[$];
  int mi[4], mm[4], ml[4];
  int pi = 0, pm = 0, pl = 0;

  function automatic int sx(int v);
    return (v >= 32768) ? v - 65536 : v;
  endfunction

  function automatic int circ_step(int cur, int st, int len);
    int p, base, o;
    if (len == 0) return (cur + st) & 16'hFFFF;
    p = 1;
    while (p < len) p = p * 2;
    base = cur - (cur % p);
    o = (cur % p) + st;
    if (o < 0) o = o + len;
    else if (o >= len) o = o - len;
    return (base + o) & 16'hFFFF;
  endfunction

  task automatic cyc(input bit rq, input int mode, input bit up,
                     input int fi, input int fm, input int fl,
                     input bit ld, input int lf, input int ls, input int ldat,
                     input string tag);
    int i, m, l, e, nv;
    bit u;
    @(negedge clk);
    req_valid = rq; req_mode = 3'(mode); req_use_ptr = up;
    req_isel = 2'(fi); req_msel = 2'(fm); req_lsel = 2'(fl);
    ld_valid = ld; ld_file = 2'(lf); ld_sel = 2'(ls); ld_data = 16'(ldat);
    u = 0; nv = 0;
    if (rq) begin
      i = up ? pi : fi; m = up ? pm : fm; l = up ? pl : fl;
      e = (mode == 4) ? (mi[i] + mm[m]) & 16'hFFFF : mi[i];
      exp_q.push_back(e); tag_q.push_back(tag);
      u = 1;
      case (mode)
        1: nv = (mi[i] + 1) & 16'hFFFF;
        2: nv = (mi[i] - 1) & 16'hFFFF;
        3: nv = (mi[i] + sx(mm[m])) & 16'hFFFF;
        5: nv = circ_step(mi[i], sx(mm[m]), ml[l]);
        6: nv = circ_step(mi[i], 1, ml[l]);
        7: nv = circ_step(mi[i], -1, ml[l]);
        default: u = 0;
      endcase
      if (u) mi[i] = nv;
    end
    if (ld) begin
      case (lf)
        0: mi[ls] = ldat & 16'hFFFF;
        1: mm[ls] = ldat & 16'hFFFF;
        2: ml[ls] = ldat & 16'hFFFF;
        default: begin
          if (ls == 0) pi = ldat & 3;
          if (ls == 1) pm = ldat & 3;
          if (ls == 2) pl = ldat & 3;
        end
      endcase
    end
  endtask

  task automatic rd(input int r, input string tag);
    cyc(1, 0, 0, r, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic acc(input int mode, input int r, input int m, input int l, input string tag);
    cyc(1, mode, 0, r, m, l, 0, 0, 0, 0, tag);
  endtask
  task automatic load(input int f, input int s, input int d);
    cyc(0, 0, 0, 0, 0, 0, 1, f, s, d, "load");
  endtask

  always @(negedge clk) begin
    #5;
    if (req_valid) begin
      int e; string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      checks++;
      if (ea !== 16'(e) || ea_valid !== 1'b1) begin
        fails++;
        $display("FAIL %s ea=%h valid=%b expected=%h valid=1", t, ea, ea_valid, 16'(e));
      end
    end else if (rst_n) begin
      checks++;
      if (ea_valid !== 1'b0) begin
        fails++;
        $display("FAIL R11 idle ea_valid=%b expected=0", ea_valid);
      end
    end
  end

  initial begin
    #(20 * 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    foreach (mi[k]) begin mi[k] = 0; mm[k] = 0; ml[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int r = 0; r < 4; r++) rd(r, "R10 reset index");
    cyc(1, 0, 1, 3, 3, 3, 0, 0, 0, 0, "R10 reset pointer");
    load(0, 0, 100); load(1, 1, 5); load(1, 2, 16'hFFFD);
    load(2, 3, 8); load(0, 1, 16'hFFFF); load(2, 1, 6);
    acc(1, 0, 0, 0, "R2 inc addr"); rd(0, "R2 inc result");
    acc(2, 0, 0, 0, "R2 dec addr"); rd(0, "R2 dec result");
    acc(1, 1, 0, 0, "R2 top wrap"); rd(1, "R2 top wrap result");
    acc(2, 1, 0, 0, "R2 bottom wrap"); rd(1, "R2 bottom wrap result");
    acc(3, 0, 2, 0, "R3 neg modify"); rd(0, "R3 neg result");
    acc(3, 0, 1, 0, "R3 pos modify"); rd(0, "R3 pos result");
    acc(4, 0, 1, 0, "R4 indexed addr"); rd(0, "R1 R4 index kept");
    acc(4, 0, 2, 0, "R4 indexed neg");
    acc(0, 0, 0, 0, "R1 plain"); rd(0, "R1 plain kept");
    load(0, 2, 37);
    for (int k = 0; k < 4; k++) acc(6, 2, 0, 3, "R5 circ inc");
    rd(2, "R5 circ inc wrap");
    for (int k = 0; k < 2; k++) acc(7, 2, 0, 3, "R5 circ dec");
    rd(2, "R5 circ dec wrap");
    load(0, 2, 68);
    acc(5, 2, 1, 1, "R5 circ mod pos"); rd(2, "R5 circ mod pos wrap");
    acc(5, 2, 2, 1, "R5 circ mod neg"); acc(5, 2, 2, 1, "R5 circ mod neg wrap");
    rd(2, "R5 circ mod neg result");
    acc(6, 0, 0, 0, "R6 len zero inc"); rd(0, "R6 linear result");
    acc(5, 0, 2, 0, "R6 len zero mod"); rd(0, "R6 linear mod result");
    load(3, 0, 2); load(3, 1, 1); load(3, 2, 1);
    cyc(1, 5, 1, 0, 0, 0, 0, 0, 0, 0, "R7 pointer select");
    rd(2, "R7 pointer target updated"); rd(0, "R7 field target untouched");
    cyc(1, 4, 1, 3, 2, 3, 0, 0, 0, 0, "R7 pointer indexed");
    cyc(1, 1, 0, 0, 0, 0, 1, 0, 0, 500, "R9 conflict addr");
    rd(0, "R9 load wins");
    cyc(1, 4, 0, 0, 1, 0, 1, 1, 1, 10, "R8 same cycle old modify");
    acc(4, 0, 1, 0, "R8 new modify");
    cyc(1, 6, 0, 3, 0, 1, 1, 2, 1, 0, "R8 same cycle old length");
    acc(6, 3, 0, 1, "R8 new length linear"); rd(3, "R8 linear result");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11 idle");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11 idle");
    @(negedge clk);
    #8;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule